// File: doc/BRIEF.md
# I2C Interrupt Flag and Vector Unit

This block sits between an I2C protocol engine and the processor's register bus. It keeps six interrupt flags: arbitration lost, not-acknowledge, start seen, stop seen, receive byte ready and transmit buffer empty. It also keeps one enable bit for each flag. From the flags that are enabled it derives a single interrupt request line and a prioritized vector code. The protocol engine reports events as single-cycle pulses. Software uses a small register port to program the enables, write the flags directly, read the receive byte, load the transmit byte and fetch the vector.

Several accesses have side effects that clear flags:
- a start event clears the stale not-acknowledge and stop flags;
- a stop event clears the start flag;
- reading the receive buffer clears the receive flag;
- loading the transmit buffer clears the transmit flag;
- fetching the vector clears the flag it reported.

When a hardware event and any clear hit the same flag in the same cycle, the hardware event wins, so no event is lost.

Top module: `i2c_irq_vec_unit`

## Requirements
- R1: After reset every flag is 0 except the transmit-empty flag, which is 1. All enables, the receive buffer and the transmit buffer are 0.
- R2: The register addresses are 0 = enables, 1 = flags, 2 = receive buffer, 3 = transmit buffer and 4 = vector. Any other address reads 0. `reg_rdata` always shows the addressed register. In the enable and flag registers the bit positions are 5 = not-acknowledge, 4 = arbitration lost, 3 = stop, 2 = start, 1 = transmit empty and 0 = receive ready, and bits 7..6 read 0.
- R3: Each event pulse sets its flag at the next edge. `ev_rx_done` also loads `eng_rx_byte` into the receive buffer. `ev_tx_taken` sets the transmit-empty flag.
- R4: A start event clears the not-acknowledge and stop flags. A stop event clears the start flag.
- R5: A read at address 2 clears the receive flag. A write at address 3 loads the transmit buffer, which drives `tx_byte`, and clears the transmit flag.
- R6: `irq` is 1 exactly when at least one flag and its matching enable are both 1.
- R7: `irq_vec` gives the highest-priority flag that is both set and enabled. The codes are 02h arbitration lost, 04h not-acknowledge, 06h start, 08h stop, 0Ah receive and 0Ch transmit. The value is 00h when nothing is pending.
- R8: A read at address 4 returns the current vector and clears the flag it names at the next edge. A read of 00h changes nothing.
- R9: For a single flag in a single cycle, a hardware set beats a software write. A software write beats any clear from an event or a side effect.
- R10: A write at address 1 sets and clears the flags directly from `reg_wdata[5:0]`. A written 1 whose enable is 1 raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_arb | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | Not-acknowledge pulse |
| ev_start | input | 1 | Start condition pulse |
| ev_stop | input | 1 | Stop condition pulse |
| ev_rx_done | input | 1 | Byte received pulse |
| eng_rx_byte | input | DATA_W | Received byte from the engine |
| ev_tx_taken | input | 1 | Transmit buffer moved to the shifter |
| tx_byte | output | DATA_W | Transmit buffer contents |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| irq_vec | output | DATA_W | Prioritized vector code |

## Verification
On every cycle the assertions check the following:
- each flag follows its set-then-write-then-clear precedence;
- a start pulse leaves the not-acknowledge flag clear;
- a receive read without a new byte leaves the receive flag clear;
- the encoder selects at most one source;
- the request line and a nonzero vector always agree.

Only the bench scenarios can show the priority order across many sources and the interplay of side-effect clears with vector fetches. They also show the byte paths through both buffers. A cycle-level model in the bench, compared each clock, covers these orderings under directed and random traffic.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NFLAG  = 6;
  localparam int ADDR_W = 3;
  localparam int B_RX   = 0;
  localparam int B_TX   = 1;
  localparam int B_STT  = 2;
  localparam int B_STP  = 3;
  localparam int B_ARB  = 4;
  localparam int B_NACK = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;

  localparam logic [ADDR_W-1:0] A_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd4;

  // Priority chain: first pending source wins, code is 2 * (rank + 1).
  function automatic logic [3:0] vec_code(input flag_vec_t pend);
    if      (pend[B_ARB])  return 4'h2;
    else if (pend[B_NACK]) return 4'h4;
    else if (pend[B_STT])  return 4'h6;
    else if (pend[B_STP])  return 4'h8;
    else if (pend[B_RX])   return 4'hA;
    else if (pend[B_TX])   return 4'hC;
    else                   return 4'h0;
  endfunction

  // Turn a code back into the one flag it names.
  function automatic flag_vec_t code_to_flag(input logic [3:0] code);
    flag_vec_t f;
    f = '0;
    case (code)
      4'h2: f[B_ARB]  = 1'b1;
      4'h4: f[B_NACK] = 1'b1;
      4'h6: f[B_STT]  = 1'b1;
      4'h8: f[B_STP]  = 1'b1;
      4'hA: f[B_RX]   = 1'b1;
      4'hC: f[B_TX]   = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/i2c_irq_flag_cell.sv
module i2c_irq_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic clr,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (hw_set)     q_nxt = 1'b1;
    else if (sw_wr) q_nxt = sw_val;
    else if (clr)   q_nxt = 1'b0;
    else            q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);
  // R9
  sw_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !hw_set) |=> (q == $past(sw_val)));
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hw_set && !sw_wr) |=> !q);
endmodule

// File: rtl/i2c_irq_prio_enc.sv
module i2c_irq_prio_enc
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flag_vec_t         pend,
  output logic [DATA_W-1:0] vec,
  output flag_vec_t         hit
);
  logic [3:0] code;

  always_comb begin
    code = vec_code(pend);
    hit  = code_to_flag(code);
    vec  = DATA_W'(code);
  end

  // R7
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R7
  hit_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~pend) == '0) && ((pend != '0) == (hit != '0)));
endmodule

// File: rtl/i2c_irq_vec_unit.sv
module i2c_irq_vec_unit
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arb,
  input  logic              ev_nack,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rx_done,
  input  logic [DATA_W-1:0] eng_rx_byte,
  input  logic              ev_tx_taken,
  output logic [DATA_W-1:0] tx_byte,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic [DATA_W-1:0] irq_vec
);
  localparam int PAD_W = DATA_W - NFLAG;

  flag_vec_t         en_q, flags, pend, hit;
  flag_vec_t         set_v, clr_v;
  logic [DATA_W-1:0] rx_buf_q, tx_buf_q;

  // Named access strobes, visible to the assertions.
  logic wr_en, wr_flag, wr_txb, rd_rxb, rd_vec;

  assign wr_en   = reg_wr && (reg_addr == A_EN);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign wr_txb  = reg_wr && (reg_addr == A_TXB);
  assign rd_rxb  = reg_rd && (reg_addr == A_RXB);
  assign rd_vec  = reg_rd && (reg_addr == A_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      rx_buf_q <= '0;
      tx_buf_q <= '0;
    end else begin
      if (wr_en)      en_q     <= reg_wdata[NFLAG-1:0];
      if (ev_rx_done) rx_buf_q <= eng_rx_byte;
      if (wr_txb)     tx_buf_q <= reg_wdata;
    end
  end

  always_comb begin
    set_v         = '0;
    set_v[B_ARB]  = ev_arb;
    set_v[B_NACK] = ev_nack;
    set_v[B_STT]  = ev_start;
    set_v[B_STP]  = ev_stop;
    set_v[B_RX]   = ev_rx_done;
    set_v[B_TX]   = ev_tx_taken;

    clr_v         = rd_vec ? hit : '0;
    clr_v[B_NACK] = clr_v[B_NACK] | ev_start;
    clr_v[B_STP]  = clr_v[B_STP]  | ev_start;
    clr_v[B_STT]  = clr_v[B_STT]  | ev_stop;
    clr_v[B_RX]   = clr_v[B_RX]   | rd_rxb;
    clr_v[B_TX]   = clr_v[B_TX]   | wr_txb;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    i2c_irq_flag_cell #(.RST_VAL(i == B_TX)) cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (set_v[i]),
      .sw_wr  (wr_flag),
      .sw_val (reg_wdata[i]),
      .clr    (clr_v[i]),
      .q      (flags[i])
    );
  end

  assign pend = flags & en_q;
  assign irq  = |pend;

  i2c_irq_prio_enc #(.DATA_W(DATA_W)) enc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .vec   (irq_vec),
    .hit   (hit)
  );

  assign tx_byte = tx_buf_q;

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = {{PAD_W{1'b0}}, en_q};
      A_FLAG:  reg_rdata = {{PAD_W{1'b0}}, flags};
      A_RXB:   reg_rdata = rx_buf_q;
      A_TXB:   reg_rdata = tx_buf_q;
      A_VEC:   reg_rdata = irq_vec;
      default: reg_rdata = '0;
    endcase
  end

  // R6
  irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_vec != '0));
  // R4
  start_drops_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_nack && !wr_flag) |=> !flags[B_NACK]);
  // R5
  rx_read_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxb && !ev_rx_done && !wr_flag) |=> !flags[B_RX]);
  // R5
  tx_byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txb |=> (tx_byte == $past(reg_wdata)));
endmodule

// File: tb/i2c_irq_vec_unit_tb_top.sv
module i2c_irq_vec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_arb = 0, ev_nack = 0, ev_start = 0, ev_stop = 0, ev_rx_done = 0, ev_tx_taken = 0;
  logic [DW-1:0] eng_rx_byte = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] tx_byte, reg_rdata, irq_vec;
  logic irq;

  int checks = 0;
  int errors = 0;

  // Reference state: bit 5 nack, 4 arb, 3 stop, 2 start, 1 tx, 0 rx.
  bit [5:0] m_flag, m_en;
  bit [7:0] m_rx, m_tx;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_vec_unit #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_arb(ev_arb), .ev_nack(ev_nack),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rx_done(ev_rx_done),
    .eng_rx_byte(eng_rx_byte), .ev_tx_taken(ev_tx_taken), .tx_byte(tx_byte),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .irq_vec(irq_vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Highest pending source in priority order, returned as the bit index, or -1.
  function automatic int m_top();
    int order[6] = '{4, 5, 2, 3, 0, 1};
    for (int k = 0; k < 6; k++)
      if (m_flag[order[k]] && m_en[order[k]]) return order[k];
    return -1;
  endfunction

  function automatic int m_code();
    int order[6] = '{4, 5, 2, 3, 0, 1};
    int t = m_top();
    for (int k = 0; k < 6; k++) if (order[k] == t) return 2 * (k + 1);
    return 0;
  endfunction

  function automatic int m_rdata(input int a);
    case (a)
      0: return m_en;
      1: return m_flag;
      2: return m_rx;
      3: return m_tx;
      4: return m_code();
      default: return 0;
    endcase
  endfunction

  // Drive one cycle of stimulus, compare outputs, then advance the model.
  task automatic step(input bit [5:0] ev, input int addr, input bit wr, input bit rd,
                      input int wd, input int rxb);
    bit [5:0] setm, clrm, nf;
    int t;
    {ev_nack, ev_arb, ev_stop, ev_start, ev_tx_taken, ev_rx_done} = ev;
    reg_addr = 3'(addr); reg_wr = wr; reg_rd = rd;
    reg_wdata = 8'(wd); eng_rx_byte = 8'(rxb);
    #1;
    check("R6 irq", irq, (m_flag & m_en) != 0);
    check("R7 vector", irq_vec, m_code());
    check("R2 read data", reg_rdata, m_rdata(addr));
    check("R5 tx byte", tx_byte, m_tx);
    setm = ev;
    clrm = '0;
    if (ev[2]) begin clrm[5] = 1; clrm[3] = 1; end
    if (ev[3]) clrm[2] = 1;
    if (rd && addr == 2) clrm[0] = 1;
    if (wr && addr == 3) clrm[1] = 1;
    t = m_top();
    if (rd && addr == 4 && t >= 0) clrm[t] = 1;
    for (int b = 0; b < 6; b++) begin
      if (setm[b]) nf[b] = 1;
      else if (wr && addr == 1) nf[b] = wd[b];
      else if (clrm[b]) nf[b] = 0;
      else nf[b] = m_flag[b];
    end
    @(posedge clk);
    m_flag = nf;
    if (wr && addr == 0) m_en = 6'(wd);
    if (wr && addr == 3) m_tx = 8'(wd);
    if (ev[0]) m_rx = 8'(rxb);
    @(negedge clk);
  endtask

  task automatic idle(); step(6'b0, 0, 0, 0, 0, 0); endtask
  task automatic rdreg(input int a); step(6'b0, a, 0, 1, 0, 0); endtask
  task automatic wrreg(input int a, input int d); step(6'b0, a, 1, 0, d, 0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_flag = 6'b000010; m_en = '0; m_rx = '0; m_tx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible through the register port
    #1;
    check("R1 flags", reg_rdata, 0);
    rdreg(1);
    check("R1 flag reg", dut_i.reg_rdata, 8'h02);
    rdreg(0);
    // R2: reserved enable bits read zero
    wrreg(0, 8'hFF);
    rdreg(0);
    // R7: only transmit pending, code 0Ch
    check("R7 tx only", irq_vec, 8'h0C);
    // R3 + R7: arbitration and nack pending, arb first
    step(6'b110000, 0, 0, 0, 0, 0);
    check("R7 arb top", irq_vec, 8'h02);
    // R8: fetching the vector clears arbitration, then nack
    rdreg(4);
    check("R8 next nack", irq_vec, 8'h04);
    rdreg(4);
    check("R8 next tx", irq_vec, 8'h0C);
    // R4: nack then start clears nack
    step(6'b100000, 0, 0, 0, 0, 0);
    step(6'b000100, 0, 0, 0, 0, 0);
    check("R4 start clears nack", irq_vec, 8'h06);
    // R4: stop clears start
    step(6'b001000, 0, 0, 0, 0, 0);
    check("R4 stop clears start", irq_vec, 8'h08);
    // R3: received byte captured
    step(6'b000001, 0, 0, 0, 0, 8'hA5);
    rdreg(4); // clears stop
    check("R3 rx code", irq_vec, 8'h0A);
    rdreg(2);
    check("R5 rx cleared", irq_vec, 8'h0C);
    // R9: new byte and buffer read in the same cycle, set wins
    step(6'b000001, 2, 0, 1, 0, 8'h3C);
    check("R9 rx kept", irq_vec, 8'h0A);
    rdreg(2);
    // R5: loading transmit buffer clears tx flag
    wrreg(3, 8'h5A);
    check("R5 tx cleared", irq, 0);
    check("R5 tx byte out", tx_byte, 8'h5A);
    step(6'b000010, 0, 0, 0, 0, 0);
    check("R3 tx taken", irq_vec, 8'h0C);
    // R10: software sets arbitration flag, then clears all
    wrreg(1, 8'h10);
    check("R10 sw set", irq_vec, 8'h02);
    wrreg(1, 8'h00);
    check("R10 sw clear", irq, 0);
    // R9: software write of 1 beats start's clear of stop
    step(6'b000100, 1, 1, 0, 8'h08, 0);
    check("R9 sw over clear", irq_vec, 8'h06);
    // R6: masked sources give no request
    wrreg(0, 8'h01);
    check("R6 masked", irq, 0);
    rdreg(4); // R8: zero vector read changes nothing
    rdreg(1);
    idle();
    // Random traffic against the model
    wrreg(0, 8'h3F);
    for (int n = 0; n < 2000; n++) begin
      bit [5:0] e;
      int a;
      int op;
      for (int b = 0; b < 6; b++) e[b] = ($urandom % 8) == 0;
      a = $urandom % 6;
      op = $urandom % 3;
      step(e, a, op == 1, op == 2, $urandom % 256, $urandom % 256);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule